// File: doc/BRIEF.md
# Linear-Sweep Frequency and Phase Accumulator

This block is the tuning engine of one direct digital synthesis channel. It holds a frequency register and a phase register. Every clock, the phase register adds the current frequency. When a linear sweep is enabled, a signed step is added to the frequency register once every programmable number of clock cycles, so the output frequency ramps up or down at a controlled rate. The phase value is the output that a later phase-to-amplitude stage would consume.

Software-style writes go into a staging bank: a tuning word, a signed step, a ramp interval and a three-bit control word. None of them reaches the running registers until an update strobe. On that strobe the staged values become active. The frequency register is loaded with a newly written tuning word, or cleared if frequency autoclear is set. The phase register is cleared if phase autoclear is set. The ramp interval counter restarts. A write made in the same cycle as the strobe waits for the next strobe.

Top module: `dds_sweep_core`

## Requirements
- R1: While reset is active and right after it is released, `freq_o`, `phase_o` and `step_tick_o` are all zero.
- R2: A tuning word, step, rate or control write changes no output until the next update strobe. A write in the same cycle as the strobe takes effect only at the following strobe.
- R3: On an update strobe where a tuning word was written since the previous strobe, `freq_o` after that edge equals the written word.
- R4: Outside update-strobe cycles, `phase_o` after each clock edge equals the previous `phase_o` plus the previous `freq_o`, modulo 2^AW.
- R5: With sweep enabled (control bit 0 = 1), interval R and signed step S, `freq_o` k edges after the update edge equals F0 + floor(k/R)·S modulo 2^AW. F0 is the value just after the update edge.
- R6: With sweep disabled (control bit 0 = 0), `freq_o` holds its value between strobes, even when a step and an interval are loaded.
- R7: An interval value of 0 behaves exactly like an interval of 1, so a step is taken on every edge.
- R8: Every update strobe restarts the interval count. The first step after a strobe comes R edges after it, whatever point the ramp had reached.
- R9: Control bit 1 is frequency autoclear. On a strobe with this bit set and no new tuning word, `freq_o` becomes 0. With a new tuning word as well, the clear is overridden and `freq_o` becomes the new word.
- R10: Control bit 2 is phase autoclear. On a strobe with this bit set, `phase_o` becomes 0. Otherwise `phase_o` becomes the previous phase plus the previous frequency. The autoclear bits used are the ones that strobe loads.
- R11: `step_tick_o` is high for one cycle after each edge at which a sweep step was applied, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tw_wr_i | input | 1 | Stage a tuning word |
| tw_data_i | input | AW | Tuning word value |
| step_wr_i | input | 1 | Stage a sweep step |
| step_data_i | input | AW | Signed sweep step |
| rate_wr_i | input | 1 | Stage a ramp interval |
| rate_data_i | input | RW | Clock cycles between sweep steps (0 acts as 1) |
| ctrl_wr_i | input | 1 | Stage a control word |
| ctrl_data_i | input | 3 | [0] sweep enable, [1] frequency autoclear, [2] phase autoclear |
| update_i | input | 1 | Update strobe: staged values become active |
| freq_o | output | AW | Current frequency register |
| phase_o | output | AW | Current phase register |
| step_tick_o | output | 1 | Pulse after each applied sweep step |

## Verification
The checker assumes that `update_i` is a clean single-cycle strobe sampled on the rising edge. It also assumes that the staged tuning word and the pending flag seen in a strobe cycle are the values left by earlier cycles. The bench therefore drives every write and strobe on the falling edge and always releases them one cycle later. The properties on frequency holding and frequency stepping are conditioned on the active enable and interval. To cover every branch of those properties, the stimulus walks through intervals 0, 1, 2, 3, 5 and 8, positive and negative steps, sweep on and off, and all autoclear combinations. Every strobe is preceded by fully settled writes.

// File: rtl/dds_sweep_pkg.sv
package dds_sweep_pkg;
  localparam int CTRL_W = 3;

  // control word layout; bit positions are part of the register interface
  typedef struct packed {
    logic clr_phase; // bit 2
    logic clr_freq;  // bit 1
    logic sweep_en;  // bit 0
  } ctrl_t;
endpackage

// File: rtl/dds_stage_bank.sv
module dds_stage_bank
  import dds_sweep_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tw_wr_i,
  input  logic [AW-1:0] tw_data_i,
  input  logic          step_wr_i,
  input  logic [AW-1:0] step_data_i,
  input  logic          rate_wr_i,
  input  logic [RW-1:0] rate_data_i,
  input  logic          ctrl_wr_i,
  input  ctrl_t         ctrl_data_i,
  input  logic          update_i,
  output logic [AW-1:0] tw_stg_o,
  output logic          tw_pend_o,
  output ctrl_t         ctrl_stg_o,
  output logic [AW-1:0] step_act_o,
  output logic [RW-1:0] rate_act_o,
  output ctrl_t         ctrl_act_o
);
  logic [AW-1:0] step_stg_q;
  logic [RW-1:0] rate_stg_q;

  // staging registers: written by the host side, no effect on the engine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tw_stg_o   <= '0;
      step_stg_q <= '0;
      rate_stg_q <= '0;
      ctrl_stg_o <= '0;
    end else begin
      if (tw_wr_i)   tw_stg_o   <= tw_data_i;
      if (step_wr_i) step_stg_q <= step_data_i;
      if (rate_wr_i) rate_stg_q <= rate_data_i;
      if (ctrl_wr_i) ctrl_stg_o <= ctrl_data_i;
    end
  end

  // a tuning word is pending from its write until the next strobe;
  // a write that coincides with a strobe stays pending for the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tw_pend_o <= 1'b0;
    else         tw_pend_o <= tw_wr_i | (tw_pend_o & ~update_i);
  end

  // active copies seen by the ramp timer and accumulators
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_act_o <= '0;
      rate_act_o <= '0;
      ctrl_act_o <= '0;
    end else if (update_i) begin
      step_act_o <= step_stg_q;
      rate_act_o <= rate_stg_q;
      ctrl_act_o <= ctrl_stg_o;
    end
  end
endmodule

// File: rtl/dds_ramp_timer.sv
module dds_ramp_timer #(
  parameter int RW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          update_i,
  input  logic          sweep_en_i,
  input  logic [RW-1:0] rate_i,
  output logic          step_evt_o
);
  localparam logic [RW-1:0] ONE = RW'(1);

  // an interval of zero is promoted to one
  function automatic logic [RW-1:0] eff_rate(input logic [RW-1:0] r);
    return (r == '0) ? ONE : r;
  endfunction

  logic [RW-1:0] cnt_q;
  logic          wrap_w;

  assign wrap_w     = (cnt_q == eff_rate(rate_i) - ONE);
  assign step_evt_o = sweep_en_i & ~update_i & wrap_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (update_i || !sweep_en_i)  cnt_q <= '0;
    else if (wrap_w)                   cnt_q <= '0;
    else                               cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/dds_accum_pair.sv
module dds_accum_pair #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          update_i,
  input  logic          load_tw_i,
  input  logic [AW-1:0] tw_i,
  input  logic          clr_freq_i,
  input  logic          clr_phase_i,
  input  logic          step_evt_i,
  input  logic [AW-1:0] step_i,
  output logic [AW-1:0] freq_o,
  output logic [AW-1:0] phase_o
);
  // frequency on a strobe: clear first, then a new word overrides the clear
  function automatic logic [AW-1:0] strobe_freq(input logic [AW-1:0] cur,
                                                input logic load, input logic [AW-1:0] tw,
                                                input logic clr);
    logic [AW-1:0] v;
    v = clr ? '0 : cur;
    if (load) v = tw;
    return v;
  endfunction

  // signed step added with wrap modulo 2^AW
  function automatic logic [AW-1:0] sweep_add(input logic [AW-1:0] cur,
                                              input logic [AW-1:0] stp);
    return cur + stp;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         freq_o <= '0;
    else if (update_i)   freq_o <= strobe_freq(freq_o, load_tw_i, tw_i, clr_freq_i);
    else if (step_evt_i) freq_o <= sweep_add(freq_o, step_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     phase_o <= '0;
    else if (update_i && clr_phase_i) phase_o <= '0;
    else                             phase_o <= phase_o + freq_o;
  end
endmodule

// File: rtl/dds_sweep_core.sv
module dds_sweep_core
  import dds_sweep_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tw_wr_i,
  input  logic [AW-1:0] tw_data_i,
  input  logic          step_wr_i,
  input  logic [AW-1:0] step_data_i,
  input  logic          rate_wr_i,
  input  logic [RW-1:0] rate_data_i,
  input  logic          ctrl_wr_i,
  input  logic [2:0]    ctrl_data_i,
  input  logic          update_i,
  output logic [AW-1:0] freq_o,
  output logic [AW-1:0] phase_o,
  output logic          step_tick_o
);
  // named internal events, also observed by the checker
  logic [AW-1:0] tw_stg_w;
  logic          tw_pend_w;
  ctrl_t         ctrl_stg_w;
  logic [AW-1:0] step_act_w;
  logic [RW-1:0] rate_act_w;
  ctrl_t         ctrl_act_w;
  logic          step_evt_w;
  logic          tick_q;

  dds_stage_bank #(.AW(AW), .RW(RW)) stage_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tw_wr_i     (tw_wr_i),
    .tw_data_i   (tw_data_i),
    .step_wr_i   (step_wr_i),
    .step_data_i (step_data_i),
    .rate_wr_i   (rate_wr_i),
    .rate_data_i (rate_data_i),
    .ctrl_wr_i   (ctrl_wr_i),
    .ctrl_data_i (ctrl_t'(ctrl_data_i)),
    .update_i    (update_i),
    .tw_stg_o    (tw_stg_w),
    .tw_pend_o   (tw_pend_w),
    .ctrl_stg_o  (ctrl_stg_w),
    .step_act_o  (step_act_w),
    .rate_act_o  (rate_act_w),
    .ctrl_act_o  (ctrl_act_w)
  );

  dds_ramp_timer #(.RW(RW)) ramp_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .update_i   (update_i),
    .sweep_en_i (ctrl_act_w.sweep_en),
    .rate_i     (rate_act_w),
    .step_evt_o (step_evt_w)
  );

  // autoclear flags come from the control word this strobe is loading
  dds_accum_pair #(.AW(AW)) accum_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .update_i    (update_i),
    .load_tw_i   (tw_pend_w),
    .tw_i        (tw_stg_w),
    .clr_freq_i  (ctrl_stg_w.clr_freq),
    .clr_phase_i (ctrl_stg_w.clr_phase),
    .step_evt_i  (step_evt_w),
    .step_i      (step_act_w),
    .freq_o      (freq_o),
    .phase_o     (phase_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= step_evt_w;
  end
  assign step_tick_o = tick_q;
endmodule

// File: rtl/dds_sweep_core_chk.sv
module dds_sweep_core_chk #(
  parameter int AW = 32,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          update,
  input logic          tw_pend,
  input logic [AW-1:0] tw_stg,
  input logic [2:0]    ctrl_stg,
  input logic          sweep_act,
  input logic [RW-1:0] rate_act,
  input logic [AW-1:0] step_act,
  input logic [AW-1:0] freq,
  input logic [AW-1:0] phase,
  input logic          tick
);
  always_comb begin
    if (!rst_n) a_r1_reset_zero: assert (freq == '0 && phase == '0 && !tick);
  end

  a_r3_load_word: assert property (@(posedge clk) disable iff (!rst_n)
    (update && tw_pend) |=> freq == $past(tw_stg));

  a_r4_phase_integrates: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> phase == $past(phase) + $past(freq));

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!update && !sweep_act) |=> $stable(freq));

  a_r5_change_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> (tick || $stable(freq)));

  a_r11_tick_adds_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!update && tick) |-> freq == $past(freq) + $past(step_act));

  a_r7_zero_rate_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!update && sweep_act && (rate_act == '0 || rate_act == RW'(1))) |=> tick);

  a_r8_no_tick_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !tick);

  a_r9_freq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (update && !tw_pend && ctrl_stg[1]) |=> freq == '0);

  a_r10_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (update && ctrl_stg[2]) |=> phase == '0);
endmodule

bind dds_sweep_core dds_sweep_core_chk #(.AW(AW), .RW(RW)) chk_i (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .update    (update_i),
  .tw_pend   (tw_pend_w),
  .tw_stg    (tw_stg_w),
  .ctrl_stg  (ctrl_stg_w),
  .sweep_act (ctrl_act_w.sweep_en),
  .rate_act  (rate_act_w),
  .step_act  (step_act_w),
  .freq      (freq_o),
  .phase     (phase_o),
  .tick      (step_tick_o)
);

// File: tb/dds_sweep_core_tb.sv
module dds_sweep_core_tb_top;
  localparam int AW = 32;
  localparam int RW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tw_wr_i = 1'b0;
  logic [AW-1:0] tw_data_i = '0;
  logic          step_wr_i = 1'b0;
  logic [AW-1:0] step_data_i = '0;
  logic          rate_wr_i = 1'b0;
  logic [RW-1:0] rate_data_i = '0;
  logic          ctrl_wr_i = 1'b0;
  logic [2:0]    ctrl_data_i = '0;
  logic          update_i = 1'b0;
  logic [AW-1:0] freq_o;
  logic [AW-1:0] phase_o;
  logic          step_tick_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  dds_sweep_core #(.AW(AW), .RW(RW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // stage values in one cycle; ctrl bits: [0] sweep, [1] freq clear, [2] phase clear
  task automatic stage(input bit do_tw, input logic [AW-1:0] tw,
                       input logic [AW-1:0] stp, input logic [RW-1:0] rate,
                       input logic [2:0] ctrl);
    @(negedge clk_i);
    tw_wr_i = do_tw; tw_data_i = tw;
    step_wr_i = 1'b1; step_data_i = stp;
    rate_wr_i = 1'b1; rate_data_i = rate;
    ctrl_wr_i = 1'b1; ctrl_data_i = ctrl;
    @(negedge clk_i);
    tw_wr_i = 1'b0; step_wr_i = 1'b0; rate_wr_i = 1'b0; ctrl_wr_i = 1'b0;
  endtask

  // returns the outputs seen just before the strobe edge
  task automatic strobe(output logic [AW-1:0] pf, output logic [AW-1:0] pp);
    @(negedge clk_i);
    pf = freq_o; pp = phase_o;
    update_i = 1'b1;
    @(negedge clk_i);
    update_i = 1'b0;
  endtask

  // closed-form check of k = 0..n edges after a strobe
  task automatic run(input string req, input logic [AW-1:0] f0, input logic [AW-1:0] p0,
                     input logic [AW-1:0] stp, input int rate, input bit en, input int n);
    int r;
    logic [AW-1:0] ef;
    logic [AW-1:0] ep;
    r = (rate == 0) ? 1 : rate;
    ep = p0;
    for (int k = 0; k <= n; k++) begin
      if (k > 0) @(negedge clk_i);
      ef = f0 + (en ? AW'(k / r) * stp : '0);
      chk(freq_o == ef, req, "freq", freq_o, ef);
      chk(phase_o == ep, (k == 0) ? "R10" : "R4", "phase", phase_o, ep);
      chk(step_tick_o == (en && k > 0 && (k % r) == 0), "R11", "tick",
          AW'(step_tick_o), AW'(en && k > 0 && (k % r) == 0));
      ep = ep + ef;
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] pf, pp;
    int rates [5] = '{1, 2, 3, 5, 8};

    #1;
    chk(freq_o == '0 && phase_o == '0 && !step_tick_o, "R1", "during reset", freq_o, '0);
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(freq_o == '0 && phase_o == '0 && !step_tick_o, "R1", "after reset", phase_o, '0);

    // R2: staged values stay invisible
    stage(1'b1, 32'd1000, 32'd5, 8'd1, 3'b101);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(freq_o == '0 && phase_o == '0, "R2", "before strobe", freq_o, '0);
    end
    stage(1'b1, 32'd1000, 32'd0, 8'd1, 3'b100);
    strobe(pf, pp);
    run("R3", 32'd1000, '0, '0, 1, 1'b0, 8);

    // R2: a word written in the strobe cycle waits for the next strobe
    @(negedge clk_i);
    tw_wr_i = 1'b1; tw_data_i = 32'd77; update_i = 1'b1;
    @(negedge clk_i);
    tw_wr_i = 1'b0; update_i = 1'b0;
    chk(freq_o == 32'd1000, "R2", "write during strobe", freq_o, 32'd1000);
    strobe(pf, pp);
    chk(freq_o == 32'd77, "R3", "deferred word", freq_o, 32'd77);

    // R5: upward sweeps over several intervals
    foreach (rates[i]) begin
      stage(1'b1, 32'd500, 32'd7, RW'(rates[i]), 3'b101);
      strobe(pf, pp);
      run("R5", 32'd500, '0, 32'd7, rates[i], 1'b1, 24);
    end

    // R5: downward sweep wrapping below zero
    stage(1'b1, 32'd5, -32'sd3, 8'd2, 3'b101);
    strobe(pf, pp);
    run("R5", 32'd5, '0, -32'sd3, 2, 1'b1, 14);

    // R7: interval 0 steps every edge
    stage(1'b1, 32'd40, 32'd4, 8'd0, 3'b101);
    strobe(pf, pp);
    run("R7", 32'd40, '0, 32'd4, 0, 1'b1, 10);

    // R6: step and interval loaded, sweep off
    stage(1'b1, 32'd300, 32'd9, 8'd1, 3'b100);
    strobe(pf, pp);
    run("R6", 32'd300, '0, 32'd9, 1, 1'b0, 10);

    // R8: strobe mid-ramp without new values restarts the count, phase continues
    stage(1'b1, 32'd10, 32'd2, 8'd3, 3'b001);
    strobe(pf, pp);
    run("R5", 32'd10, pp + pf, 32'd2, 3, 1'b1, 4);
    strobe(pf, pp);
    run("R8", pf, pp + pf, 32'd2, 3, 1'b1, 10);

    // R9: frequency clear without a new word, phase kept
    stage(1'b0, '0, 32'd1, 8'd2, 3'b011);
    strobe(pf, pp);
    run("R9", '0, pp + pf, 32'd1, 2, 1'b1, 8);

    // R9: clear and new word together -> new word wins; R10 phase clear
    stage(1'b1, 32'd4242, 32'd0, 8'd1, 3'b110);
    strobe(pf, pp);
    run("R9", 32'd4242, '0, '0, 1, 1'b0, 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule